// File: doc/BRIEF.md
# Fixed-Point Biquad Section

A single second-order recursive filter section working on signed 24-bit samples (one sign bit, 23 fraction bits). It is built to be one stage of a longer chain of such sections. Each accepted sample is first scaled by a small stage gain, so the strongly resonant recursion keeps its internal values in range. The fixed numerator 1, 2, 1 is then formed with a shift and two adds, and two feedback products are subtracted. The result is returned to sample scale and clamped to the 24-bit range. That clamped value is both the output and the value fed back.

Coefficients and gain are integers scaled by 2^15, supplied as parameters. The feedback coefficients need a signed format with a sign bit and one integer bit, because the first one exceeds 1 in magnitude. All products are summed in one wide accumulator, and only the final sum is shifted right by 15. A sample is taken on any cycle where `in_valid_i` is high, and the filtered result appears on the next cycle.

Top module: `biquad_section`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it rises, `out_valid_o` is 0 and `out_data_o` is 0. All four history values (two past inputs, two past outputs) are cleared to zero.
- R2: `out_valid_o` is high in exactly the cycles that follow a cycle with `in_valid_i` high.
- R3: For an accepted sample x with past inputs x1, x2 and past outputs y1, y2, the output is floor((G*(x + 2*x1 + x2) - A1*y1 - A2*y2) / 2^15). This value is computed without intermediate wrap and is then clamped. The defaults are A1 = -61383, A2 = 28747 and G = 33, which are the values -1.87326116, 0.87728056 and about 0.001 scaled by 2^15 and rounded.
- R4: A result above 8388607 is output as 8388607 (0x7FFFFF), and a result below -8388608 is output as -8388608 (0x800000). The clamped value, not the unclamped one, becomes the next y1.
- R5: In cycles with `in_valid_i` low, the history does not advance and `out_data_o` holds its last value. A sample that follows any number of idle cycles gives the same result as one sent back to back.
- R6: The gain G is a parameter. Overriding it changes the output exactly as the R3 formula predicts, with the same A1 and A2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input sample strobe |
| in_data_i | input | 24 | Signed input sample |
| out_valid_o | output | 1 | Output sample strobe |
| out_data_o | output | 24 | Signed, clamped output sample |

## Verification
The bench keeps the default widths and feedback coefficients, but overrides the stage gain to 1024 (0.03125). This raises the DC gain of the section to about 31. Full-scale steps of either sign then drive the output into both clamps and hold it there, which brings the feedback of clamped values within reach. Small impulses, low-level steps, an amplitude sweep of impulses and random samples with random idle gaps stay in the linear range. They are compared bit-exactly against an integer model of the R3 formula, and a mid-run reset shows that the history is cleared.

// File: rtl/biquad_pkg.sv
package biquad_pkg;
  localparam int unsigned BQ_DATA_W  = 24;
  localparam int unsigned BQ_FRAC_W  = 15;
  localparam int unsigned BQ_ACC_W   = 48;
  // coefficients scaled by 2^15, rounded
  localparam int          BQ_A1_DEF  = -61383;
  localparam int          BQ_A2_DEF  = 28747;
  localparam int          BQ_GAIN_DEF = 33;
endpackage

// File: rtl/bq_delay_line.sv
module bq_delay_line #(
  parameter int unsigned W     = 24,
  parameter int unsigned DEPTH = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic [W-1:0]              d_i,
  output logic [DEPTH-1:0][W-1:0]   taps_o
);
  logic [DEPTH-1:0][W-1:0] q;

  for (genvar k = 0; k < DEPTH; k++) begin : g_tap
    logic [W-1:0] nxt;
    if (k == 0) begin : g_head
      assign nxt = d_i;
    end else begin : g_body
      assign nxt = q[k-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q[k] <= '0;
      else if (en_i) q[k] <= nxt;
    end
  end

  assign taps_o = q;
endmodule

// File: rtl/bq_numerator.sv
module bq_numerator #(
  parameter int unsigned W = 24,
  localparam int unsigned SW = W + 2
) (
  input  logic [W-1:0]  x0_i,
  input  logic [W-1:0]  x1_i,
  input  logic [W-1:0]  x2_i,
  output logic [SW-1:0] sum_o
);
  logic [SW-1:0] e0, e1x2, e2;

  // taps 1,2,1: shift for the middle tap, no multiplier
  assign e0    = {{2{x0_i[W-1]}}, x0_i};
  assign e1x2  = {x1_i[W-1], x1_i, 1'b0};
  assign e2    = {{2{x2_i[W-1]}}, x2_i};
  assign sum_o = e0 + e1x2 + e2;
endmodule

// File: rtl/bq_accum.sv
module bq_accum #(
  parameter int unsigned NUM_W  = 26,
  parameter int unsigned DW     = 24,
  parameter int unsigned ACC_W  = 48,
  parameter int          GAIN_Q = 33,
  parameter int          A1_Q   = -61383,
  parameter int          A2_Q   = 28747
) (
  input  logic [NUM_W-1:0]        num_i,
  input  logic [DW-1:0]           y1_i,
  input  logic [DW-1:0]           y2_i,
  output logic signed [ACC_W-1:0] acc_o
);
  localparam logic signed [ACC_W-1:0] K_G  = ACC_W'(GAIN_Q);
  localparam logic signed [ACC_W-1:0] K_A1 = ACC_W'(A1_Q);
  localparam logic signed [ACC_W-1:0] K_A2 = ACC_W'(A2_Q);

  logic signed [ACC_W-1:0] num_e, y1_e, y2_e;
  logic signed [ACC_W-1:0] p_g, p_a1, p_a2;

  assign num_e = {{(ACC_W-NUM_W){num_i[NUM_W-1]}}, num_i};
  assign y1_e  = {{(ACC_W-DW){y1_i[DW-1]}}, y1_i};
  assign y2_e  = {{(ACC_W-DW){y2_i[DW-1]}}, y2_i};

  assign p_g   = K_G  * num_e;
  assign p_a1  = K_A1 * y1_e;
  assign p_a2  = K_A2 * y2_e;
  assign acc_o = p_g - p_a1 - p_a2;
endmodule

// File: rtl/bq_saturate.sv
module bq_saturate #(
  parameter int unsigned ACC_W  = 48,
  parameter int unsigned FRAC_W = 15,
  parameter int unsigned DW     = 24
) (
  input  logic signed [ACC_W-1:0] acc_i,
  output logic [DW-1:0]           y_o
);
  localparam logic signed [ACC_W-1:0] HI = ACC_W'((64'sd1 <<< (DW-1)) - 1);
  localparam logic signed [ACC_W-1:0] LO = -ACC_W'(64'sd1 <<< (DW-1));

  logic signed [ACC_W-1:0] sc;

  assign sc = acc_i >>> FRAC_W;  // floor divide by 2^FRAC_W

  always_comb begin
    if (sc > HI)      y_o = {1'b0, {(DW-1){1'b1}}};
    else if (sc < LO) y_o = {1'b1, {(DW-1){1'b0}}};
    else              y_o = sc[DW-1:0];
  end
endmodule

// File: rtl/biquad_section.sv
module biquad_section #(
  parameter int unsigned DATA_W = biquad_pkg::BQ_DATA_W,
  parameter int unsigned FRAC_W = biquad_pkg::BQ_FRAC_W,
  parameter int unsigned ACC_W  = biquad_pkg::BQ_ACC_W,
  parameter int          GAIN_Q = biquad_pkg::BQ_GAIN_DEF,
  parameter int          A1_Q   = biquad_pkg::BQ_A1_DEF,
  parameter int          A2_Q   = biquad_pkg::BQ_A2_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o
);
  localparam int unsigned NUM_W = DATA_W + 2;
  localparam int unsigned HIST  = 2;

  logic [HIST-1:0][DATA_W-1:0] x_hist, y_hist;
  logic [NUM_W-1:0]            num_w;
  logic signed [ACC_W-1:0]     acc_w;
  logic [DATA_W-1:0]           y_next;

  bq_delay_line #(.W(DATA_W), .DEPTH(HIST)) i_x_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (in_valid_i),
    .d_i    (in_data_i),
    .taps_o (x_hist)
  );

  bq_numerator #(.W(DATA_W)) i_num (
    .x0_i  (in_data_i),
    .x1_i  (x_hist[0]),
    .x2_i  (x_hist[1]),
    .sum_o (num_w)
  );

  bq_accum #(
    .NUM_W(NUM_W), .DW(DATA_W), .ACC_W(ACC_W),
    .GAIN_Q(GAIN_Q), .A1_Q(A1_Q), .A2_Q(A2_Q)
  ) i_acc (
    .num_i (num_w),
    .y1_i  (y_hist[0]),
    .y2_i  (y_hist[1]),
    .acc_o (acc_w)
  );

  bq_saturate #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .DW(DATA_W)) i_sat (
    .acc_i (acc_w),
    .y_o   (y_next)
  );

  // clamped result feeds back; newest output tap is the port value
  bq_delay_line #(.W(DATA_W), .DEPTH(HIST)) i_y_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (in_valid_i),
    .d_i    (y_next),
    .taps_o (y_hist)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_valid_o <= 1'b0;
    else         out_valid_o <= in_valid_i;
  end

  assign out_data_o = y_hist[0];
endmodule

// File: rtl/biquad_section_chk.sv
module biquad_section_chk #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned FRAC_W = 15,
  parameter int unsigned ACC_W  = 48
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    in_valid_i,
  input logic                    out_valid_o,
  input logic [DATA_W-1:0]       out_data_o,
  input logic signed [ACC_W-1:0] acc_w
);
  localparam logic signed [ACC_W-1:0] HI = ACC_W'((64'sd1 <<< (DATA_W-1)) - 1);
  localparam logic signed [ACC_W-1:0] LO = -ACC_W'(64'sd1 <<< (DATA_W-1));
  localparam logic [DATA_W-1:0] MAXV = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MINV = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc_q;
  assign acc_q = acc_w >>> FRAC_W;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_clear : assert (out_valid_o == 1'b0 && out_data_o == '0)
        else $error("R1 outputs not cleared in reset");
    end
  end

  a_r2_valid_follows : assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  a_r2_no_spurious : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  a_r5_hold_idle : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(out_data_o));
  a_r4_clamp_hi : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && acc_q > HI) |=> out_data_o == MAXV);
  a_r4_clamp_lo : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && acc_q < LO) |=> out_data_o == MINV);
endmodule

bind biquad_section biquad_section_chk #(
  .DATA_W(DATA_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o),
  .acc_w       (acc_w)
);

// File: tb/test_biquad_section.sv
module test_biquad_section;
  localparam int  DW   = 24;
  localparam int  GQ   = 1024;    // R6: gain override
  localparam longint A1 = -61383; // R3 defaults
  localparam longint A2 = 28747;
  localparam longint MAXV = 8388607;
  localparam longint MINV = -8388608;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          in_valid_i = 1'b0;
  logic [DW-1:0] in_data_i = '0;
  logic          out_valid_o;
  logic [DW-1:0] out_data_o;

  int n_chk = 0;
  int n_bad = 0;
  longint x1 = 0, x2 = 0, y1 = 0, y2 = 0;

  always #2 clk_i = ~clk_i;

  biquad_section #(.GAIN_Q(GQ)) i_biquad_section (
    .clk_i, .rst_ni, .in_valid_i, .in_data_i, .out_valid_o, .out_data_o
  );

  function automatic longint sx(input logic [DW-1:0] v);
    return longint'($signed(v));
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R3/R4 model: wide sum, floor shift, clamp, feed back clamped value
  function automatic longint model(input longint x);
    longint acc, v;
    acc = longint'(GQ) * (x + 2 * x1 + x2) - A1 * y1 - A2 * y2;
    v = acc >>> 15;
    if (v > MAXV) v = MAXV;
    if (v < MINV) v = MINV;
    x2 = x1; x1 = x;
    y2 = y1; y1 = v;
    return v;
  endfunction

  task automatic push(input longint x, input string req);
    longint e;
    in_valid_i = 1'b1;
    in_data_i  = x[DW-1:0];
    e = model(x);
    @(negedge clk_i);
    check("R2", longint'(out_valid_o), 1);
    check(req, sx(out_data_o), e);
  endtask

  task automatic idle(input int n);
    in_valid_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      check("R2", longint'(out_valid_o), 0);
      check("R5", sx(out_data_o), y1);
    end
  endtask

  task automatic do_reset();
    in_valid_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1", longint'(out_valid_o), 0);
    check("R1", sx(out_data_o), 0);
    rst_ni = 1'b1;
    x1 = 0; x2 = 0; y1 = 0; y2 = 0;
    @(negedge clk_i);
    check("R1", longint'(out_valid_o), 0);
    check("R1", sx(out_data_o), 0);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    do_reset();

    // R3: impulse response, linear range
    push(1 << 18, "R3");
    for (int i = 0; i < 60; i++) push(0, "R3");
    idle(3);

    // R3: low-level step
    for (int i = 0; i < 120; i++) push(3000, "R3");
    for (int i = 0; i < 120; i++) push(-3000, "R3");

    // R1: mid-run reset clears history, then impulse must match fresh model
    do_reset();
    push(-(1 << 17), "R1");
    for (int i = 0; i < 10; i++) push(0, "R1");

    // R4: full-scale steps drive both clamps, clamped value fed back
    for (int i = 0; i < 150; i++) push(MAXV, "R4");
    for (int i = 0; i < 150; i++) push(MINV, "R4");
    for (int i = 0; i < 150; i++) push(0, "R4");

    // R6/R3: amplitude sweep of impulses
    do_reset();
    for (longint a = -(1 << 20); a <= (1 << 20); a += (1 << 16)) begin
      push(a, "R6");
      for (int i = 0; i < 6; i++) push(0, "R6");
    end

    // R5: random samples with random idle gaps
    for (int i = 0; i < 400; i++) begin
      longint r;
      r = longint'($signed(16'($urandom)));
      push(r, "R5");
      if (($urandom % 3) == 0) idle(1 + int'($urandom % 4));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule